// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write Ethernet PHY registers over the two-wire management interface (MDC clock, bidirectional MDIO data). The host works through two 32-bit words. The command word carries the target PHY and register addresses, a clock-range code, a direction bit and a start/busy flag. The data word carries the 16-bit register value.

A write of the command word with the start bit set launches one clause-22 frame. The block divides the system clock down to MDC using the ratio the clock-range code selects, and shifts the frame out. For a read it releases MDIO and shifts in the PHY's answer. When the frame is complete it clears the busy flag. Software loads the data word before a PHY write. After a PHY read it polls busy and then reads the result from the data word.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command word reads back as PHY address in bits 15:11, register address in bits 10:6, clock-range code in bits 5:2, direction in bit 1 (1 = PHY write, 0 = PHY read) and busy in bit 0. Bits 31:16 read as zero. A command write with bit 0 clear updates the fields and starts nothing.
- R2: The MDC period in system clocks is 16 for code 2, 26 for code 3, 42 for code 0, 62 for code 1, 102 for code 4 and 124 for code 5. Codes 6 to 15 give 42.
- R3: Writing the command word with bit 0 set makes busy read 1 from the next cycle. Busy stays 1 until the frame ends and then returns to 0. MDC is low whenever busy is 0.
- R4: A write frame is sent MSB first as 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data bits. The master drives MDIO for all 64 bits.
- R5: A read frame sends 32 ones, start 01, opcode 10, PHY address and register address. The output enable is then 0 for the turnaround and the 16 data bits. The 16 bits sampled on MDC rising edges, MSB first, are in data word bits 15:0 when busy clears.
- R6: MDIO output value and output enable change only together with a falling MDC edge while a frame runs.
- R7: A command-word write while busy is 1 is ignored. The fields keep their values and no second frame starts.
- R8: A host write to the data word reads back whole. Its bits 15:0 are the value a PHY write transmits.
- R9: Each frame lasts exactly 64 MDC periods (64 rising edges).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Target word: 0 = command, 1 = data |
| host_wdata | input | 32 | Host write value |
| cmd_word | output | 32 | Command word read value |
| data_word | output | 32 | Data word read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The assertions check on every cycle that MDC rests low while idle, that busy only falls when a frame ends, that the drive changes only on falling MDC edges, that MDIO is released through a read's turnaround and data, and that command writes during busy leave the fields untouched. Only the bench scenarios can show the actual frame bit order, the MDC period for each code including the fallback codes, the read value landing in the data word, and that an ignored start launches no second frame. The bench shows these with a PHY model that records every bit on the rising MDC edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int ADDR_W     = 5;
    localparam int CODE_W     = 4;
    localparam int DATA_W     = 16;
    localparam int HALF_W     = 7;
    localparam int TA_IDX     = 46;  // first turnaround bit
    localparam int RD_IDX     = 48;  // first data bit

    localparam logic SEL_CMD  = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    // half of the MDC period in system clocks, per clock-range code
    function automatic logic [HALF_W-1:0] half_period(input logic [CODE_W-1:0] code);
        case (code)
            4'd1:    half_period = 7'd31;
            4'd2:    half_period = 7'd8;
            4'd3:    half_period = 7'd13;
            4'd4:    half_period = 7'd51;
            4'd5:    half_period = 7'd62;
            default: half_period = 7'd21;
        endcase
    endfunction

    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [CODE_W-1:0] code;
        logic              wr;
        logic              busy;
        logic [31:0]       data;
    } host_regs_t;
endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              mdc,
    output logic              rise_tick,
    output logic              fall_tick
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              mdc;
    } gen_t;

    gen_t              g_d, g_q;
    logic [HALF_W-1:0] half;

    always_comb begin
        half      = half_period(code);
        g_d       = g_q;
        rise_tick = 1'b0;
        fall_tick = 1'b0;
        if (!run) begin
            g_d.cnt = '0;
            g_d.mdc = 1'b0;
        end else if (g_q.cnt == half - 7'd1) begin
            g_d.cnt   = '0;
            g_d.mdc   = ~g_q.mdc;
            rise_tick = ~g_q.mdc;
            fall_tick = g_q.mdc;
        end else begin
            g_d.cnt = g_q.cnt + 7'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign mdc = g_q.mdc;

    // R3: the clock is parked low whenever the generator is stopped
    p_stop_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdo,
    output logic              mdoe
);
    typedef struct packed {
        logic                  active;
        logic                  wr;
        logic [FRAME_BITS-1:0] sh;
        logic [IDX_W-1:0]      idx;
        logic [DATA_W-1:0]     rx;
        logic                  mdo;
        logic                  oe;
    } seq_t;

    seq_t                  s_d, s_q;
    logic [FRAME_BITS-1:0] frame;
    logic [IDX_W:0]        nxt;

    always_comb begin
        frame = {32'hFFFF_FFFF, 2'b01, (is_wr ? 2'b01 : 2'b10), phy, regad,
                 (is_wr ? 2'b10 : 2'b11), (is_wr ? wdata : 16'hFFFF)};
        nxt   = {1'b0, s_q.idx} + 1'b1;
        s_d   = s_q;
        done  = 1'b0;
        if (!s_q.active) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.wr     = is_wr;
                s_d.sh     = frame;
                s_d.idx    = '0;
                s_d.mdo    = frame[FRAME_BITS-1];
                s_d.oe     = 1'b1;
            end
        end else begin
            if (rise_tick && !s_q.wr && s_q.idx >= IDX_W'(RD_IDX))
                s_d.rx = {s_q.rx[DATA_W-2:0], mdio_i};
            if (fall_tick) begin
                if (s_q.idx == IDX_W'(FRAME_BITS-1)) begin
                    s_d.active = 1'b0;
                    s_d.mdo    = 1'b0;
                    s_d.oe     = 1'b0;
                    done       = 1'b1;
                end else begin
                    s_d.idx = nxt[IDX_W-1:0];
                    s_d.sh  = {s_q.sh[FRAME_BITS-2:0], 1'b0};
                    s_d.mdo = s_q.sh[FRAME_BITS-2];
                    s_d.oe  = s_q.wr || (nxt < (IDX_W+1)'(TA_IDX));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.active;
    assign rdata  = s_q.rx;
    assign mdo    = s_q.mdo;
    assign mdoe   = s_q.oe;

    // R6: drive changes only at a falling MDC edge inside a frame
    p_drive_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !fall_tick) |=> ($stable(mdo) && $stable(mdoe)));

    // R5: line released from turnaround onward during a read
    p_release_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !s_q.wr && s_q.idx >= IDX_W'(TA_IDX)) |-> !mdoe);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] cmd_word,
    output logic [31:0] data_word,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    host_regs_t        r_d, r_q;
    logic              seq_active, seq_done, seq_start;
    logic              rise_tick, fall_tick;
    logic [DATA_W-1:0] seq_rdata;

    assign seq_start = r_q.busy && !seq_active;

    always_comb begin
        r_d = r_q;
        if (host_wr && host_sel == SEL_DATA)
            r_d.data = host_wdata;
        if (host_wr && host_sel == SEL_CMD && !r_q.busy) begin
            r_d.phy   = host_wdata[15:11];
            r_d.regad = host_wdata[10:6];
            r_d.code  = host_wdata[5:2];
            r_d.wr    = host_wdata[1];
            r_d.busy  = host_wdata[0];
        end
        if (seq_done) begin
            r_d.busy = 1'b0;
            if (!r_q.wr) r_d.data[DATA_W-1:0] = seq_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    mdc_clkgen u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (seq_active),
        .code      (r_q.code),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_start),
        .is_wr     (r_q.wr),
        .phy       (r_q.phy),
        .regad     (r_q.regad),
        .wdata     (r_q.data[DATA_W-1:0]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .active    (seq_active),
        .done      (seq_done),
        .rdata     (seq_rdata),
        .mdo       (mdio_o),
        .mdoe      (mdio_oe)
    );

    assign cmd_word  = {16'h0, r_q.phy, r_q.regad, r_q.code, r_q.wr, r_q.busy};
    assign data_word = r_q.data;

    // R3: MDC parked low while idle
    p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.busy |-> !mdc);

    // R3: busy falls only as the frame finishes
    p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.busy) |-> $past(seq_done));

    // R7: command fields frozen while busy
    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && host_wr && host_sel == SEL_CMD) |=>
            ($stable(r_q.phy) && $stable(r_q.regad) && $stable(r_q.code) && $stable(r_q.wr)));
endmodule

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] cmd_word, data_word;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;  // 250 MHz

    mdio_mgmt_master dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .cmd_word(cmd_word), .data_word(data_word),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: records each bit on rising MDC, answers reads
    logic [63:0] cap_v, cap_e;
    logic [15:0] phy_resp = '0;
    int          nrise = 0;
    time         last_t = 0, period = 0;

    always @(posedge mdc) begin
        cap_v = {cap_v[62:0], mdio_o};
        cap_e = {cap_e[62:0], mdio_oe};
        if (nrise > 0) period = $time - last_t;
        last_t = $time;
        nrise  = nrise + 1;
    end

    always @(negedge mdc) begin
        if (nrise >= 48 && nrise < 64) mdio_i = phy_resp[63 - nrise];
        else                           mdio_i = 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [31:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (cmd_word[0] == 1'b0) break;
        end
    endtask

    function automatic int ratio_of(input logic [3:0] c);
        case (c)
            4'd1: return 62;
            4'd2: return 16;
            4'd3: return 26;
            4'd4: return 102;
            4'd5: return 124;
            default: return 42;
        endcase
    endfunction

    // vector: {code, wr, phy, reg, value}; value = write data or PHY answer
    localparam int NV = 8;
    localparam logic [30:0] VEC [NV] = '{
        {4'd0,  1'b1, 5'd1,  5'd0,  16'hA5C3},
        {4'd0,  1'b0, 5'd1,  5'd2,  16'h1234},
        {4'd2,  1'b1, 5'd31, 5'd31, 16'hFFFF},
        {4'd3,  1'b0, 5'd0,  5'd0,  16'h0001},
        {4'd1,  1'b0, 5'd17, 5'd9,  16'h8000},
        {4'd4,  1'b1, 5'd5,  5'd21, 16'h0000},
        {4'd5,  1'b0, 5'd12, 5'd3,  16'hBEEF},
        {4'd9,  1'b1, 5'd8,  5'd30, 16'h5A5A}
    };

    initial begin : watchdog
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [63:0] exp_f, exp_e;
        logic [31:0] c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cmd", {32'h0, cmd_word}, 64'h0);
        chk("R8 reset data", {32'h0, data_word}, 64'h0);
        chk("R3 reset mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);

        for (int v = 0; v < NV; v++) begin
            logic [3:0]  code;
            logic        wr;
            logic [4:0]  pa, ra;
            logic [15:0] val;
            {code, wr, pa, ra, val} = VEC[v];
            nrise = 0; period = 0;
            if (wr) host_write(1'b1, {16'hC0DE, val});
            else    begin phy_resp = val; host_write(1'b1, 32'hDEAD_0000); end
            if (wr) chk("R8 data readback", {32'h0, data_word}, {32'h0, 16'hC0DE, val});
            c = {16'h0, pa, ra, code, wr, 1'b1};
            host_write(1'b0, c);
            chk("R3 busy after start", {32'h0, cmd_word}, {32'h0, c});
            wait_idle();
            chk("R3 busy clears", {63'h0, cmd_word[0]}, 64'h0);
            chk("R3 mdc low after", {63'h0, mdc}, 64'h0);
            chk("R9 rising edges", 64'(nrise), 64'd64);
            chk("R2 mdc period", 64'(period), 64'(ratio_of(code) * 4));
            if (wr) begin
                exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, val};
                chk("R4 write frame", cap_v, exp_f);
                chk("R4 write drive", cap_e, {64{1'b1}});
            end else begin
                exp_e = {{46{1'b1}}, 18'h0};
                exp_f = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 18'h0};
                chk("R5 read header", cap_v & exp_e, exp_f);
                chk("R5 read release", cap_e, exp_e);
                chk("R5 read data", {32'h0, data_word}, {32'h0, 16'hDEAD, val});
            end
        end

        // R1: fields without start
        host_write(1'b0, 32'h0000_FFFE);
        chk("R1 field readback", {32'h0, cmd_word}, 64'h0000_0000_0000_FFFE);
        repeat (200) @(negedge clk);
        chk("R1 no start without bit0", {63'h0, cmd_word[0]}, 64'h0);
        chk("R3 mdc idle", {63'h0, mdc}, 64'h0);

        // R7: command writes ignored while busy
        nrise = 0; phy_resp = 16'h0F0F;
        c = {16'h0, 5'd3, 5'd4, 4'd2, 1'b0, 1'b1};
        host_write(1'b0, c);
        repeat (200) @(negedge clk);
        host_write(1'b0, {16'h0, 5'd7, 5'd9, 4'd4, 1'b1, 1'b1});
        chk("R7 fields kept", {32'h0, cmd_word}, {32'h0, c});
        wait_idle();
        chk("R7 original phy sent", {59'h0, cap_v[27:23]}, 64'd3);
        chk("R7 original reg sent", {59'h0, cap_v[22:18]}, 64'd4);
        repeat (600) @(negedge clk);
        chk("R7 no second frame", 64'(nrise), 64'd64);
        chk("R7 stays idle", {63'h0, cmd_word[0]}, 64'h0);
        chk("R5 read data after R7", {48'h0, data_word[15:0]}, 64'h0F0F);

        // R2: highest code falls back
        nrise = 0; period = 0;
        host_write(1'b0, {16'h0, 5'd2, 5'd2, 4'd15, 1'b1, 1'b1});
        wait_idle();
        chk("R2 code 15 period", 64'(period), 64'd168);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule